// File: doc/BRIEF.md
# SDLC Transmit Framer with CRC Priority

This block turns a stream of bytes into a bit-serial SDLC/HDLC line signal, one line bit per clock. While it is enabled and has nothing to send, it fills the line with flags. When a byte arrives in its single-entry holding register, the next flag boundary becomes the opening flag and data follows, least significant bit first. A zero is inserted after five consecutive ones of frame content. When a byte finishes and no further byte is waiting, the block signals end-of-message, appends a 16-bit frame check sequence and a closing flag. A byte written while the check sequence and the closing flag are still pending is held for the following frame, so it cannot cut the current frame short.

The transmitter stops only at character boundaries. If it is turned off during the check sequence, the full sixteen bit times are still sent, but the bits that remain are taken from the flag pattern. In auto-enable mode the clear-to-send input gates the transmitter. An active-low request-to-send output follows a control bit and can drop by itself when a frame closes. The line can be NRZ or NRZI coded, and in NRZI mode the line can be held high after a closing flag instead of sending idle flags.

Top module: `sdlc_tx_framer`

## Requirements
- R1: After reset `txd` is 1. While the transmitter is effectively enabled and no frame is active, flags of value 0x7E are sent back to back, bit 0 first, with no zero insertion. Every line bit appears on `txd` one clock after the cycle in which it is chosen.
- R2: Data bytes go out bit 0 first. A byte held when a character ends is sent right after it within the same frame. After any five consecutive ones drawn from data or check bits, one extra 0 is sent and the bit that was next is delayed by one clock.
- R3: When a data byte ends and the holding register is empty, `eom` is high for exactly one clock, in the clock in which the first check bit is chosen. The 16-bit check sequence is then sent, followed by one closing flag 0x7E. The check uses polynomial x^16+x^12+x^5+1 in reflected form (0x8408). It is preset to 0xFFFF when a frame's first byte starts, and it is sent complemented, register bit 0 first.
- R4: Turning the effective enable off never cuts a flag or a data byte. The character in progress finishes, and then `txd` stays 1. If this happens during data, no check sequence or closing flag follows. When the enable returns, a flag is sent before any data.
- R5: If the effective enable is off in any clock of the check sequence, all 16 check bit times are still sent. From that clock on, check bit k (k = 0..15) is replaced by bit k mod 8 of 0x7E, with no zero insertion. After the sixteenth bit no closing flag follows and `txd` stays 1.
- R6: The effective enable is `tx_en` AND (NOT `auto_en` OR NOT `cts_n`). With `auto_en` = 0, `cts_n` has no effect on the line.
- R7: A byte written after `eom` while the check sequence or the closing flag is still pending is not sent in the current frame. It becomes the first byte of the next frame, which uses the closing flag as its opening flag. `tbe` stays 0 from that write until the byte starts.
- R8: `tbe` is 1 exactly when the holding register is empty. A write (`wr_valid` = 1) is accepted only while `tbe` = 1, and a write while `tbe` = 0 is ignored. A held byte is taken only at a character boundary.
- R9: `rts_n` is the inverse of `rts_bit` while automatic deactivation has not fired.
- R10: With `auto_rts_off` = 1, a closing flag that is not followed directly by data drives `rts_n` to 1. It stays 1 until `rts_bit` is cleared and set again.
- R11: With `nrzi_en` = 1, a 0 line bit toggles `txd` and a 1 line bit keeps it. When no frame is active the line rests at 1.
- R12: With `nrzi_en` = 1 and `nrzi_mark` = 1, a closing flag with no byte waiting is followed by a constant 1 on `txd` instead of idle flags. A later byte causes a flag and then the data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one line bit per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Transmitter enable control bit |
| auto_en | input | 1 | Makes clear-to-send gate the transmitter |
| cts_n | input | 1 | Clear-to-send, active low |
| rts_bit | input | 1 | Request-to-send control bit |
| auto_rts_off | input | 1 | Drop request-to-send after a closing flag |
| nrzi_en | input | 1 | NRZI line coding select |
| nrzi_mark | input | 1 | Hold the line high after a closing flag (NRZI only) |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| txd | output | 1 | Serial line output |
| rts_n | output | 1 | Request-to-send, active low |
| tbe | output | 1 | Holding register empty |
| eom | output | 1 | One-clock end-of-message event |

## Verification
Two functions can fall in the same cycle. The first is the end-of-message decision at a data byte boundary. The second is a byte write into the holding register, which either extends the frame or must wait for the next one. The bench provokes the clash by writing a byte in the cycle right after `eom` is seen. It also turns the transmitter off a few bits into the check sequence, so the substitution rule and the boundary decision meet. A behavioural bit-queue model predicts `txd`, `tbe`, `eom` and `rts_n` in every clock and judges both cases, together with an explicit check that `tbe` stays low while the byte waits.

// File: rtl/sdlc_tx_framer.sv
module sdlc_tx_framer #(
  parameter logic [7:0]  FLAG_PAT  = 8'h7E,
  parameter logic [15:0] CRC_POLY  = 16'h8408,
  parameter int unsigned STUFF_RUN = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_en,
  input  logic       auto_en,
  input  logic       cts_n,
  input  logic       rts_bit,
  input  logic       auto_rts_off,
  input  logic       nrzi_en,
  input  logic       nrzi_mark,
  input  logic       wr_valid,
  input  logic [7:0] wr_data,
  output logic       txd,
  output logic       rts_n,
  output logic       tbe,
  output logic       eom
);
  localparam int unsigned BYTE_W = $bits(FLAG_PAT);
  localparam int unsigned CRC_W  = $bits(CRC_POLY);
  localparam int unsigned CNT_W  = $clog2(CRC_W);
  localparam int unsigned IDX_W  = $clog2(BYTE_W);
  localparam int unsigned RUN_W  = $clog2(STUFF_RUN + 1);

  typedef enum logic [2:0] {S_OFF, S_FLAG, S_DATA, S_CRC, S_CLOSE, S_MARK} phase_t;

  phase_t state, nxt;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] sh, hold;
  logic [CRC_W-1:0]  crc;
  logic [RUN_W-1:0]  ones;
  logic hold_full, subst, line, drop, eom_q;
  logic en_eff, st_off, st_mark, st_crc, active, stuff, sub_now;
  logic cur_bit, out_bit, stuffable, adv, last, decide, take;

  assign en_eff    = tx_en & (~auto_en | ~cts_n);
  assign st_off    = state == S_OFF;
  assign st_mark   = state == S_MARK;
  assign st_crc    = state == S_CRC;
  assign active    = ~st_off & ~st_mark;
  assign stuff     = active & (ones == RUN_W'(STUFF_RUN));
  assign sub_now   = subst | ~en_eff;
  assign cur_bit   = st_crc ? (sub_now ? FLAG_PAT[bitcnt[IDX_W-1:0]] : ~crc[0]) : sh[0];
  assign out_bit   = cur_bit & ~stuff;
  assign stuffable = (state == S_DATA) | (st_crc & ~sub_now);
  assign adv       = active & ~stuff;
  assign last      = bitcnt == (st_crc ? CNT_W'(CRC_W - 1) : CNT_W'(BYTE_W - 1));
  assign decide    = (adv & last) | ~active;
  assign take      = decide & (nxt == S_DATA);

  assign txd   = line;
  assign tbe   = ~hold_full;
  assign eom   = eom_q;
  assign rts_n = ~(rts_bit & ~drop);

  always_comb begin
    nxt = state;
    case (state)
      S_OFF:  if (en_eff) nxt = S_FLAG;
      S_MARK: if (!en_eff) nxt = S_OFF;
              else if (hold_full) nxt = S_FLAG;
      S_FLAG, S_CLOSE:
        if (!en_eff) nxt = S_OFF;
        else if (hold_full) nxt = S_DATA;
        else if (state == S_CLOSE && nrzi_en && nrzi_mark) nxt = S_MARK;
        else nxt = S_FLAG;
      S_DATA:
        if (!en_eff) nxt = S_OFF;
        else if (hold_full) nxt = S_DATA;
        else nxt = S_CRC;
      S_CRC:  nxt = sub_now ? S_OFF : S_CLOSE;
      default: nxt = S_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_OFF;
      bitcnt    <= '0;
      sh        <= '0;
      hold      <= '0;
      hold_full <= 1'b0;
      crc       <= '1;
      ones      <= '0;
      subst     <= 1'b0;
      line      <= 1'b1;
      drop      <= 1'b0;
      eom_q     <= 1'b0;
    end else begin
      if (decide) begin
        state  <= nxt;
        bitcnt <= '0;
        subst  <= 1'b0;
        if (take) begin
          sh        <= hold;
          hold_full <= 1'b0;
        end else begin
          sh <= FLAG_PAT;
        end
      end else begin
        if (adv) begin
          bitcnt <= bitcnt + CNT_W'(1);
          sh     <= sh >> 1;
        end
        if (st_crc & ~en_eff) subst <= 1'b1;
      end

      if (wr_valid & ~hold_full) begin
        hold      <= wr_data;
        hold_full <= 1'b1;
      end

      if (adv & (state == S_DATA))
        crc <= (crc >> 1) ^ ((crc[0] ^ sh[0]) ? CRC_POLY : '0);
      else if (adv & st_crc)
        crc <= crc >> 1;
      else if (take)
        crc <= '1;

      if (!adv) ones <= '0;
      else      ones <= (stuffable & cur_bit) ? ones + RUN_W'(1) : '0;

      line  <= active ? (nrzi_en ? (out_bit ? line : ~line) : out_bit) : 1'b1;
      eom_q <= decide & (state == S_DATA) & (nxt == S_CRC);

      if (!rts_bit) drop <= 1'b0;
      else if (auto_rts_off & decide & (state == S_CLOSE) & (nxt != S_DATA)) drop <= 1'b1;
    end
  end
endmodule

// File: rtl/sdlc_tx_framer_chk.sv
module sdlc_tx_framer_chk #(
  parameter int unsigned RUN_MAX = 5,
  parameter int unsigned RUN_W   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             txd,
  input logic             tbe,
  input logic             eom,
  input logic             rts_bit,
  input logic             rts_n,
  input logic             auto_en,
  input logic             cts_n,
  input logic             st_off,
  input logic             st_mark,
  input logic             st_crc,
  input logic             take,
  input logic [RUN_W-1:0] ones
);
  a_r2_run_limit: assert property (@(posedge clk) disable iff (!rst_n)
    ones <= RUN_W'(RUN_MAX));

  a_r3_eom_single: assert property (@(posedge clk) disable iff (!rst_n)
    eom |=> !eom);

  a_r3_eom_starts_crc: assert property (@(posedge clk) disable iff (!rst_n)
    eom |-> st_crc);

  a_r7_crc_keeps_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (st_crc && !tbe) |=> !tbe);

  a_r8_full_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (!tbe && !take) |=> !tbe);

  a_r6_cts_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && cts_n && st_off) |=> st_off);

  a_r9_rts_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    !rts_bit |-> rts_n);

  a_r4_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    st_off |=> txd);

  a_r12_mark_high: assert property (@(posedge clk) disable iff (!rst_n)
    st_mark |=> txd);
endmodule

bind sdlc_tx_framer sdlc_tx_framer_chk #(.RUN_MAX(STUFF_RUN), .RUN_W(RUN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .tbe(tbe), .eom(eom),
  .rts_bit(rts_bit), .rts_n(rts_n), .auto_en(auto_en), .cts_n(cts_n),
  .st_off(st_off), .st_mark(st_mark), .st_crc(st_crc), .take(take), .ones(ones)
);

// File: tb/sdlc_tx_framer_tb.sv
module sdlc_tx_framer_tb_top;
  localparam int PH_OFF = 0, PH_FLAG = 1, PH_DATA = 2, PH_CRC = 3, PH_CLOSE = 4, PH_MARK = 5;
  localparam logic [7:0] FLAGV = 8'h7E;

  logic clk = 0, rst_n = 0;
  logic tx_en = 0, auto_en = 0, cts_n = 1, rts_bit = 0, auto_rts_off = 0;
  logic nrzi_en = 0, nrzi_mark = 0, wr_valid = 0;
  logic [7:0] wr_data = '0;
  logic txd, rts_n, tbe, eom;

  int checks = 0, fails = 0;
  bit done = 0;

  sdlc_tx_framer dut_i (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .auto_en(auto_en), .cts_n(cts_n),
    .rts_bit(rts_bit), .auto_rts_off(auto_rts_off), .nrzi_en(nrzi_en),
    .nrzi_mark(nrzi_mark), .wr_valid(wr_valid), .wr_data(wr_data),
    .txd(txd), .rts_n(rts_n), .tbe(tbe), .eom(eom)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: got %h expected %h", tag, $time, act, exp);
    end
  endtask

  // behavioural reference: bit queue per character
  bit q[$];
  int ph = PH_OFF, run = 0, pos = 0;
  logic [15:0] mcrc = '1;
  logic [7:0] mhold = '0;
  bit msub = 0, mline = 1, mfull = 0, meom = 0, mdrop = 0;
  string ttag = "R1";

  task automatic model_step();
    bit en, wr_ok, b, bnd, act, stf;
    int nx;
    en = tx_en && (!auto_en || !cts_n);
    wr_ok = wr_valid && !mfull;
    bnd = 0;
    act = (ph == PH_FLAG) || (ph == PH_DATA) || (ph == PH_CRC) || (ph == PH_CLOSE);
    meom = 0;
    if (act) begin
      if (ph == PH_CRC && !en && !msub) begin
        msub = 1;
        foreach (q[i]) q[i] = FLAGV[(pos + i) % 8];
      end
      if (run == 5) begin
        b = 0; run = 0; ttag = "R2";
      end else begin
        b = q.pop_front();
        stf = (ph == PH_DATA) || (ph == PH_CRC && !msub);
        if (ph == PH_DATA) mcrc = (mcrc >> 1) ^ ((mcrc[0] ^ b) ? 16'h8408 : 16'h0000);
        run = (stf && b) ? run + 1 : 0;
        pos++;
        bnd = (q.size() == 0);
        case (ph)
          PH_FLAG: ttag = "R1";
          PH_DATA: ttag = "R2";
          PH_CRC:  ttag = msub ? "R5" : "R3";
          default: ttag = "R3";
        endcase
      end
      if (nrzi_en) begin
        if (!b) mline = !mline;
        ttag = "R11";
      end else mline = b;
    end else begin
      mline = 1; run = 0;
      ttag = (ph == PH_MARK) ? "R12" : "R4";
    end
    if (bnd || !act) begin
      nx = ph;
      case (ph)
        PH_OFF:  if (en) nx = PH_FLAG;
        PH_MARK: if (!en) nx = PH_OFF; else if (mfull) nx = PH_FLAG;
        PH_FLAG, PH_CLOSE:
          if (!en) nx = PH_OFF;
          else if (mfull) nx = PH_DATA;
          else if (ph == PH_CLOSE && nrzi_en && nrzi_mark) nx = PH_MARK;
          else nx = PH_FLAG;
        PH_DATA: if (!en) nx = PH_OFF; else if (mfull) nx = PH_DATA; else nx = PH_CRC;
        default: nx = msub ? PH_OFF : PH_CLOSE;
      endcase
      if (rts_bit && auto_rts_off && ph == PH_CLOSE && nx != PH_DATA) mdrop = 1;
      if (ph == PH_DATA && nx == PH_CRC) meom = 1;
      pos = 0; msub = 0; q.delete();
      case (nx)
        PH_FLAG, PH_CLOSE: for (int k = 0; k < 8; k++) q.push_back(FLAGV[k]);
        PH_DATA: begin
          if (ph != PH_DATA) mcrc = '1;
          for (int k = 0; k < 8; k++) q.push_back(mhold[k]);
          mfull = 0;
        end
        PH_CRC: for (int k = 0; k < 16; k++) q.push_back(~mcrc[k]);
        default: ;
      endcase
      ph = nx;
    end
    if (!rts_bit) mdrop = 0;
    if (wr_ok) begin mfull = 1; mhold = wr_data; end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = PH_OFF; q.delete(); mcrc = '1; run = 0; pos = 0;
      msub = 0; mline = 1; mfull = 0; meom = 0; mdrop = 0;
    end else model_step();
  end

  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk(txd === mline, ttag, 16'(txd), 16'(mline));
      chk(tbe === !mfull, "R8", 16'(tbe), 16'(!mfull));
      chk(eom === meom, "R3", 16'(eom), 16'(meom));
      chk(rts_n === !(rts_bit && !mdrop), mdrop ? "R10" : "R9", 16'(rts_n), 16'(!(rts_bit && !mdrop)));
    end
  end

  task automatic put_byte(input logic [7:0] b);
    while (!tbe) @(negedge clk);
    wr_valid = 1; wr_data = b;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic wait_eom();
    do @(negedge clk); while (!eom);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog R1: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(txd == 1'b1, "R1 reset txd", 16'(txd), 16'h1);
    chk(tbe == 1'b1, "R8 reset tbe", 16'(tbe), 16'h1);
    chk(eom == 1'b0, "R3 reset eom", 16'(eom), 16'h0);
    chk(rts_n == 1'b1, "R9 reset rts_n", 16'(rts_n), 16'h1);

    // idle flags, cts_n high but auto_en off (R1, R6)
    tx_en = 1;
    repeat (30) @(negedge clk);

    // frame with stuffing, then a write right after eom (R2, R3, R7)
    put_byte(8'hFF); put_byte(8'h1F); put_byte(8'hF8); put_byte(8'h7E); put_byte(8'h00);
    wait_eom();
    put_byte(8'hA5);
    chk(tbe == 1'b0, "R7 byte held during check sequence", 16'(tbe), 16'h0);
    repeat (5) @(negedge clk);
    chk(tbe == 1'b0, "R7 byte still held", 16'(tbe), 16'h0);
    put_byte(8'h3C);
    if (!tbe) begin
      wr_valid = 1; wr_data = 8'h00; // R8 write while full is ignored
      @(negedge clk);
      wr_valid = 0;
    end
    wait_eom();
    repeat (40) @(negedge clk);

    // disable mid data (R4)
    put_byte(8'hC3); put_byte(8'h99);
    repeat (3) @(negedge clk);
    tx_en = 0;
    repeat (40) @(negedge clk);
    chk(txd == 1'b1, "R4 line high after stop", 16'(txd), 16'h1);
    tx_en = 1;
    wait_eom();
    repeat (40) @(negedge clk);

    // disable during check sequence (R5)
    put_byte(8'h12); put_byte(8'h34);
    wait_eom();
    repeat (6) @(negedge clk);
    tx_en = 0;
    repeat (30) @(negedge clk);
    chk(txd == 1'b1, "R5 line high after substituted check", 16'(txd), 16'h1);
    tx_en = 1;
    repeat (20) @(negedge clk);

    // auto enables (R6)
    auto_en = 1; cts_n = 1;
    repeat (30) @(negedge clk);
    chk(txd == 1'b1, "R6 cts high blocks", 16'(txd), 16'h1);
    cts_n = 0;
    repeat (30) @(negedge clk);
    auto_en = 0; cts_n = 1;

    // rts and auto deactivation (R9, R10)
    rts_bit = 1;
    @(negedge clk);
    chk(rts_n == 1'b0, "R9 rts follows bit", 16'(rts_n), 16'h0);
    auto_rts_off = 1;
    put_byte(8'hAA);
    wait_eom();
    repeat (40) @(negedge clk);
    chk(rts_n == 1'b1, "R10 rts dropped after frame", 16'(rts_n), 16'h1);
    rts_bit = 0;
    @(negedge clk);
    rts_bit = 1;
    @(negedge clk);
    chk(rts_n == 1'b0, "R10 rts re-armed", 16'(rts_n), 16'h0);
    auto_rts_off = 0;

    // NRZI (R11)
    nrzi_en = 1;
    put_byte(8'hF0); put_byte(8'h0F);
    wait_eom();
    repeat (40) @(negedge clk);

    // NRZI mark after closing flag (R12)
    nrzi_mark = 1;
    put_byte(8'h81);
    wait_eom();
    repeat (40) @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      chk(txd == 1'b1, "R12 mark hold", 16'(txd), 16'h1);
      @(negedge clk);
    end
    put_byte(8'h66);
    wait_eom();
    repeat (40) @(negedge clk);

    done = 1;
    summary();
    $finish;
  end
endmodule